// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer of 64 words, each 4 bits wide. Two level strobes drive it. A rising edge on the shift-in strobe stores the word on the data inputs. A falling edge on the shift-out strobe discards the word shown on the outputs. The oldest stored word moves to the data outputs without any read request, and a valid flag reports when it is there. A second flag reports when another word can be accepted. The two strobes are asynchronous to the block. Each passes through a two-flop synchronizer clocked by the system clock, and all sequencing happens on that clock. A word therefore reaches the outputs a small, fixed number of clocks after the strobe edge that enables it.

Two pass-through cases are defined at the limits of the buffer:
- **Empty buffer, shift-out held high.** A word shifted in moves to the outputs, the valid flag pulses for one clock, and the word is consumed at once. Its value stays visible on the outputs.
- **Full buffer, shift-in held high.** Removing a word makes the ready flag pulse for one clock, and the waiting input word is then stored without a new strobe edge.

An active-low master reset empties the buffer and clears the outputs.

The input side is a three-state machine:
- `IS_OPEN`: ready flag high.
- `IS_HELD`: a word was captured and the strobe is still high.
- `IS_FULL`: no room.

Its transitions are:
- *capture*: `IS_OPEN`→`IS_HELD`, taken when the strobe is high.
- *release*: `IS_HELD`→`IS_OPEN`, or `IS_HELD`→`IS_FULL` when the buffer is full at that moment, taken when the strobe goes low.
- *room*: `IS_FULL`→`IS_OPEN`, taken when a word leaves.

The output side is a four-state machine:
- `OS_VACANT`: nothing shown.
- `OS_SHOW`: valid word shown.
- `OS_DRAIN`: shift-out strobe high, flag low.
- `OS_PASS`: one-clock valid pulse while shift-out is already high.

Its transitions are:
- *load*: `OS_VACANT`→`OS_SHOW`, or `OS_VACANT`→`OS_PASS` when shift-out is high.
- *arm*: `OS_SHOW`→`OS_DRAIN`.
- *retire*: `OS_DRAIN`→`OS_VACANT`, on shift-out low.
- *auto-retire*: `OS_PASS`→`OS_VACANT`.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds up to 64 words of 4 bits, and the data outputs present them in the exact order they were stored. The outputs are non-inverted copies of the stored bits.
- R2: The word on `din` is stored when `shift_in` rises. Once `shift_in` is low again and no valid word is shown, the oldest word appears on `dout` within 6 clocks.
- R3: A falling edge of `shift_out` while a valid word is shown removes that word. The next stored word, if any, appears on `dout` within 6 clocks.
- R4: A `shift_in` pulse while 64 words are stored stores nothing. A `shift_out` pulse while no valid word is shown removes nothing.
- R5: After the last word leaves, `dout` keeps its value until a new word is loaded or reset is asserted.
- R6: `out_ready` (1 = valid word on `dout`) is low whenever the buffer is empty. It is low from one clock after `shift_out` is seen high.
- R7: `in_ready` (1 = a word can be accepted) is low from one clock after `shift_in` is seen high until `shift_in` is low again. It stays low while 64 words are stored.
- R8: With `shift_out` held high on an empty buffer, a shifted-in word is driven onto `dout`, `out_ready` is high for exactly one clock, and the buffer is empty afterwards.
- R9: With 64 words stored and `shift_in` held high, a `shift_out` pulse makes `in_ready` high for exactly one clock, and the waiting `din` word is stored as the newest entry.
- R10: While `rst_n` is 0, the buffer is emptied, `in_ready` is 1, `out_ready` is 0 and `dout` is all zeros.
- R11: If `shift_in` is high when `rst_n` returns to 1, that word is stored and `in_ready` stays low until `shift_in` falls. If `shift_in` fell before the release, nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst_n | input | 1 | Active-low asynchronous master reset |
| din | input | 4 | Word to store; held stable while `shift_in` is high |
| shift_in | input | 1 | Store strobe; a rising edge stores `din` |
| shift_out | input | 1 | Remove strobe; a falling edge removes the shown word |
| dout | output | 4 | Oldest word, or the last word shown |
| in_ready | output | 1 | High when a word can be accepted |
| out_ready | output | 1 | High when `dout` carries a valid word |

## Verification
The hardest case to reach is the full-buffer pass-through. It needs all 64 locations filled, `shift_in` held high while the ready flag is already low, and then a remove pulse. After that the bench must catch a single-clock rise of `in_ready` and confirm that the held input word lands behind the 63 older words. To get there, the bench fills the buffer with a counting pattern, parks a distinct value on `din` with the strobe high, and counts the clocks `in_ready` is high during the remove pulse. It then drains everything and requires the parked value to come out last. The empty-side pass-through is reached the same way, with `shift_out` parked high and the clocks of high `out_ready` counted.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
    typedef enum logic [1:0] {
        IS_OPEN = 2'd0,
        IS_HELD = 2'd1,
        IS_FULL = 2'd2
    } in_state_t;

    typedef enum logic [1:0] {
        OS_VACANT = 2'd0,
        OS_SHOW   = 2'd1,
        OS_DRAIN  = 2'd2,
        OS_PASS   = 2'd3
    } out_state_t;
endpackage

// File: rtl/ftf_sync.sv
module ftf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain <= d;
        end else begin : g_multi
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ftf_store.sv
module ftf_store #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    fill
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/ftf_in_ctl.sv
module ftf_in_ctl
    import ftf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic si,
    input  logic full,
    output logic push,
    output logic held,
    output logic ready
);
    in_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IS_OPEN;
        else        state <= nxt;
    end

    always_comb begin
        nxt   = state;
        push  = 1'b0;
        ready = 1'b0;
        held  = 1'b0;
        unique case (state)
            IS_OPEN: begin
                ready = 1'b1;
                if (si) begin
                    push = 1'b1;
                    nxt  = IS_HELD;
                end
            end
            IS_HELD: begin
                held = 1'b1;
                if (!si) nxt = full ? IS_FULL : IS_OPEN;
            end
            IS_FULL: begin
                if (!full) nxt = IS_OPEN;
            end
            default: nxt = IS_OPEN;
        endcase
    end
endmodule

// File: rtl/ftf_out_ctl.sv
module ftf_out_ctl
    import ftf_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             so,
    input  logic             avail,
    input  logic [WIDTH-1:0] head,
    output logic             pop,
    output logic             valid,
    output logic [WIDTH-1:0] dout
);
    out_state_t state, nxt;
    logic       load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OS_VACANT;
            dout  <= '0;
        end else begin
            state <= nxt;
            if (load) dout <= head;
        end
    end

    always_comb begin
        nxt   = state;
        load  = 1'b0;
        pop   = 1'b0;
        valid = 1'b0;
        unique case (state)
            OS_VACANT: begin
                if (avail) begin
                    load = 1'b1;
                    nxt  = so ? OS_PASS : OS_SHOW;
                end
            end
            OS_SHOW: begin
                valid = 1'b1;
                if (so) nxt = OS_DRAIN;
            end
            OS_DRAIN: begin
                if (!so) begin
                    pop = 1'b1;
                    nxt = OS_VACANT;
                end
            end
            OS_PASS: begin
                valid = 1'b1;
                pop   = 1'b1;
                nxt   = OS_VACANT;
            end
            default: nxt = OS_VACANT;
        endcase
    end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int WIDTH       = 4,
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             shift_in,
    input  logic             shift_out,
    output logic [WIDTH-1:0] dout,
    output logic             in_ready,
    output logic             out_ready
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic si_q, so_q;
    logic push, pop, held, full, avail;
    logic [WIDTH-1:0] head;
    logic [CW-1:0]    fill;

    ftf_sync #(.STAGES(SYNC_STAGES)) u_si_sync (.clk(clk), .d(shift_in),  .q(si_q));
    ftf_sync #(.STAGES(SYNC_STAGES)) u_so_sync (.clk(clk), .d(shift_out), .q(so_q));

    ftf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(din),
        .pop(pop), .head(head), .fill(fill)
    );

    assign full  = (fill == CAP);
    // the word captured by a strobe still high is not yet eligible to fall through
    assign avail = held ? (fill > CW'(1)) : (fill != '0);

    ftf_in_ctl u_in (
        .clk(clk), .rst_n(rst_n), .si(si_q), .full(full),
        .push(push), .held(held), .ready(in_ready)
    );

    ftf_out_ctl #(.WIDTH(WIDTH)) u_out (
        .clk(clk), .rst_n(rst_n), .so(so_q), .avail(avail), .head(head),
        .pop(pop), .valid(out_ready), .dout(dout)
    );
endmodule

module ftf_checker #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             si_s,
    input logic             so_s,
    input logic [CW-1:0]    fill,
    input logic             in_ready,
    input logic             out_ready,
    input logic [WIDTH-1:0] dout
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R1
    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CW'(DEPTH)) |-> !in_ready); // R7
    AST_IR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && si_s) |=> !in_ready); // R7
    AST_OR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && so_s) |=> !out_ready); // R6
    AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !out_ready); // R6
    AST_EMPTY_HOLDS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill == '0) && ($past(fill) == '0)) |-> $stable(dout)); // R5
endmodule

bind strobe_fifo ftf_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .si_s(si_q), .so_s(so_q), .fill(fill),
    .in_ready(in_ready), .out_ready(out_ready), .dout(dout)
);

// File: tb/strobe_fifo_bench.sv
`timescale 1ns/1ps
module strobe_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] din = '0;
    logic       shift_in = 1'b0;
    logic       shift_out = 1'b0;
    logic [3:0] dout;
    logic       in_ready, out_ready;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    strobe_fifo u_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .din(din), .shift_in(shift_in),
        .shift_out(shift_out), .dout(dout), .in_ready(in_ready), .out_ready(out_ready)
    );

    // {op(0 push,1 pop), data, expected dout, expected out_ready, expected in_ready}
    localparam logic [10:0] VEC [12] = '{
        {1'b0, 4'h3, 4'h3, 1'b1, 1'b1},
        {1'b0, 4'hA, 4'h3, 1'b1, 1'b1},
        {1'b0, 4'h7, 4'h3, 1'b1, 1'b1},
        {1'b1, 4'h0, 4'hA, 1'b1, 1'b1},
        {1'b1, 4'h0, 4'h7, 1'b1, 1'b1},
        {1'b1, 4'h0, 4'h7, 1'b0, 1'b1},
        {1'b1, 4'h0, 4'h7, 1'b0, 1'b1},
        {1'b0, 4'hC, 4'hC, 1'b1, 1'b1},
        {1'b0, 4'h1, 4'hC, 1'b1, 1'b1},
        {1'b1, 4'h0, 4'h1, 1'b1, 1'b1},
        {1'b1, 4'h0, 4'h1, 1'b0, 1'b1},
        {1'b1, 4'h0, 4'h1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [3:0] d);
        din = d;
        shift_in = 1'b1;
        wait_clk(6);
        shift_in = 1'b0;
        wait_clk(6);
    endtask

    task automatic pop();
        shift_out = 1'b1;
        wait_clk(6);
        shift_out = 1'b0;
        wait_clk(6);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic count_ir(input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (in_ready) hi++;
        end
    endtask

    task automatic count_or(input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (out_ready) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        wait_clk(4);
        // R10 reset state
        chk("R10 dout in reset", dout, 0);
        chk("R10 in_ready in reset", in_ready, 1);
        chk("R10 out_ready in reset", out_ready, 0);
        rst_n = 1'b1;
        wait_clk(3);

        // table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][10] == 1'b0) begin
                din = VEC[i][9:6];
                shift_in = 1'b1;
                wait_clk(6);
                chk("R7 in_ready low while shift_in high", in_ready, 0);
                shift_in = 1'b0;
                wait_clk(6);
            end else begin
                shift_out = 1'b1;
                wait_clk(6);
                chk("R6 out_ready low while shift_out high", out_ready, 0);
                shift_out = 1'b0;
                wait_clk(6);
            end
            chk("R1 R2 R3 R5 table dout", dout, VEC[i][5:2]);
            chk("R4 R6 table out_ready", out_ready, VEC[i][1]);
            chk("R7 table in_ready", in_ready, VEC[i][0]);
        end

        // R10 reset clears contents and outputs
        push(4'h5);
        push(4'h6);
        do_reset();
        chk("R10 dout after reset", dout, 0);
        chk("R10 out_ready after reset", out_ready, 0);
        chk("R10 in_ready after reset", in_ready, 1);

        // fill to capacity, overflow ignored, ordered drain: R1 R4 R7
        for (int i = 0; i < 64; i++) push(4'(i));
        chk("R7 in_ready low when full", in_ready, 0);
        push(4'h5);
        chk("R1 head after fill", dout, 0);
        for (int i = 1; i < 64; i++) begin
            pop();
            chk("R1 drain order", dout, i % 16);
        end
        pop();
        chk("R4 extra word not stored", out_ready, 0);
        chk("R5 last word held", dout, 15);
        pop();
        chk("R4 pop on empty ignored", dout, 15);
        chk("R7 in_ready after drain", in_ready, 1);

        // full-side pass-through: R9
        do_reset();
        for (int i = 0; i < 64; i++) push(4'(i));
        din = 4'h9;
        shift_in = 1'b1;
        wait_clk(6);
        chk("R7 full with shift_in held", in_ready, 0);
        shift_out = 1'b1;
        wait_clk(6);
        shift_out = 1'b0;
        count_ir(14, hi);
        chk("R9 single in_ready pulse", hi, 1);
        shift_in = 1'b0;
        wait_clk(6);
        chk("R9 full again after auto store", in_ready, 0);
        chk("R3 next word after pop", dout, 1);
        for (int i = 2; i <= 64; i++) begin
            pop();
            chk("R9 drain order with auto word", dout, (i < 64) ? (i % 16) : 9);
        end
        pop();
        chk("R9 empty after drain", out_ready, 0);

        // empty-side pass-through: R8
        do_reset();
        shift_out = 1'b1;
        wait_clk(6);
        din = 4'h6;
        shift_in = 1'b1;
        wait_clk(6);
        shift_in = 1'b0;
        count_or(14, hi);
        chk("R8 single out_ready pulse", hi, 1);
        chk("R8 word on dout", dout, 6);
        shift_out = 1'b0;
        wait_clk(6);
        chk("R8 buffer empty afterwards", out_ready, 0);
        push(4'h2);
        chk("R8 next word not stale", dout, 2);

        // R11 shift_in high at reset release
        rst_n = 1'b0;
        din = 4'hB;
        shift_in = 1'b1;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(6);
        chk("R11 in_ready low after release with shift_in high", in_ready, 0);
        shift_in = 1'b0;
        wait_clk(6);
        chk("R11 word stored at release", dout, 11);
        chk("R11 out_ready", out_ready, 1);
        chk("R11 in_ready after shift_in falls", in_ready, 1);

        // R11 shift_in dropped before release
        rst_n = 1'b0;
        din = 4'hD;
        shift_in = 1'b1;
        wait_clk(3);
        shift_in = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(8);
        chk("R11 nothing stored", out_ready, 0);
        chk("R11 in_ready high", in_ready, 1);
        chk("R11 dout zero", dout, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule